// File: doc/BRIEF.md
# Protected PLL Feedback Divider

This block is the digital side of a clock multiplier. It keeps three configuration registers on a byte-wide register bus: a 12-bit multiplier split across a high and a low byte, and an 8-bit VCO range word. It runs a modulo-N counter on the oscillator clock that emits one feedback pulse every N input clocks. The external loop compares that pulse with the reference.

A loop-enable input (`pll_on`) starts the divider and also locks the configuration. While it is high, every write to the multiplier or range registers is dropped, so the running loop never sees its ratio change underneath it. A programmed multiplier of zero divides by one. The upper four bits of the multiplier high byte are not implemented and read as zero.

Top module: `pll_fb_divider`

## Requirements
- R1: After reset, the multiplier high byte (address 0x37) reads 0x00, the low byte (address 0x38) reads 0x40, the range register (address 0x3A) reads 0x40, and `mul_value` equals 64.
- R2: With `pll_on` low, a write takes effect on the clock edge that samples `wr_en`. The new value reads back on `rd_data` in the next cycle. The low byte drives `mul_value[7:0]` and bits 3..0 of the high byte drive `mul_value[11:8]`.
- R3: Bits 7..4 of the multiplier high byte always read 0, including after a write of ones into them.
- R4: A write to either multiplier byte on an edge where `pll_on` is 1 is discarded, and the stored multiplier stays unchanged.
- R5: The range register holds all 8 written bits. A write to it on an edge where `pll_on` is 1 is discarded.
- R6: While `pll_on` stays 1, `fb_pulse` is high for exactly one cycle in every N cycles, where N is `mul_value`. The first pulse appears in the cycle that follows the N-th rising edge at which `pll_on` is sampled high.
- R7: When `mul_value` is 0, the divider behaves as if N were 1: `fb_pulse` is high in every cycle after the first enabled edge.
- R8: `fb_pulse` is 0 in any cycle where `pll_on` is 0.
- R9: A read of any address other than 0x37, 0x38 or 0x3A returns 0x00.
- R10: A write presented in the same cycle that `pll_on` rises is discarded. A write presented in the cycle that `pll_on` is dropped back to 0 is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; also the clock that is divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| pll_on | input | 1 | Loop enable; runs the divider and locks configuration writes |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| fb_pulse | output | 1 | One-cycle feedback pulse at terminal count |
| mul_value | output | 12 | Stored multiplier N |
| range_value | output | 8 | Stored VCO range word |

## Verification
A configuration write and the loop enable can land in the same cycle. The bench provokes this in both directions. It raises `pll_on` together with a multiplier write and expects the old value to read back. It then drops `pll_on` together with a write and expects the new value. The divider is also started from a multiplier of zero, of the default 64, and of small odd values. The pulse positions are judged cycle by cycle from the rising edge of `pll_on`.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

   // Register selected by the current bus address
   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_MUL_HI = 2'd1,
      SEL_MUL_LO = 2'd2,
      SEL_RANGE  = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/pfd_cfg_regs.sv
module pfd_cfg_regs
   import pfd_pkg::*;
#(
   parameter int                DATA_W   = 8,
   parameter int                ADDR_W   = 8,
   parameter int                MUL_W    = 12,
   parameter logic [ADDR_W-1:0] ADDR_HI  = 8'h37,
   parameter logic [ADDR_W-1:0] ADDR_LO  = 8'h38,
   parameter logic [ADDR_W-1:0] ADDR_RNG = 8'h3A,
   parameter logic [MUL_W-1:0]  MUL_RST  = 12'h040,
   parameter logic [DATA_W-1:0] RNG_RST  = 8'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pll_on,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output reg_sel_e          sel,
   output logic [MUL_W-1:0]  mul_q,
   output logic [DATA_W-1:0] rng_q
);

   localparam int HI_W = MUL_W - DATA_W;

   logic wr_ok;

   always_comb begin
      if (addr == ADDR_HI)       sel = SEL_MUL_HI;
      else if (addr == ADDR_LO)  sel = SEL_MUL_LO;
      else if (addr == ADDR_RNG) sel = SEL_RANGE;
      else                       sel = SEL_NONE;
   end

   // Configuration is frozen whenever the loop is enabled
   assign wr_ok = wr_en & ~pll_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mul_q <= MUL_RST;
         rng_q <= RNG_RST;
      end else if (wr_ok) begin
         case (sel)
            SEL_MUL_HI: mul_q[MUL_W-1:DATA_W] <= wr_data[HI_W-1:0];
            SEL_MUL_LO: mul_q[DATA_W-1:0]     <= wr_data;
            SEL_RANGE:  rng_q                 <= wr_data;
            default:    ;
         endcase
      end
   end

endmodule

// File: rtl/pfd_read_mux.sv
module pfd_read_mux
   import pfd_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int MUL_W  = 12
) (
   input  reg_sel_e          sel,
   input  logic [MUL_W-1:0]  mul_q,
   input  logic [DATA_W-1:0] rng_q,
   output logic [DATA_W-1:0] rd_data
);

   localparam int HI_W = MUL_W - DATA_W;

   logic [DATA_W-1:0] hi_view;

   generate
      if (HI_W < DATA_W) begin : g_hi_pad
         // unimplemented upper bits of the high byte read as zero
         assign hi_view = {{(DATA_W-HI_W){1'b0}}, mul_q[MUL_W-1:DATA_W]};
      end else begin : g_hi_full
         assign hi_view = mul_q[MUL_W-1:DATA_W];
      end
   endgenerate

   always_comb begin
      case (sel)
         SEL_MUL_HI: rd_data = hi_view;
         SEL_MUL_LO: rd_data = mul_q[DATA_W-1:0];
         SEL_RANGE:  rd_data = rng_q;
         default:    rd_data = '0;
      endcase
   end

endmodule

// File: rtl/pfd_mod_counter.sv
module pfd_mod_counter #(
   parameter int MUL_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pll_on,
   input  logic [MUL_W-1:0] mul,
   output logic             pulse
);

   logic [MUL_W-1:0] n_eff;
   logic [MUL_W-1:0] reload;
   logic [MUL_W-1:0] cnt;
   logic             running;
   logic             at_tc;

   // zero is treated as one
   assign n_eff  = (mul == '0) ? MUL_W'(1) : mul;
   assign reload = n_eff - MUL_W'(1);
   assign at_tc  = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (!pll_on) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (!running) begin
         running <= 1'b1;
         cnt     <= reload;
      end else if (at_tc) begin
         cnt     <= reload;
      end else begin
         cnt     <= cnt - MUL_W'(1);
      end
   end

   assign pulse = running & pll_on & at_tc;

endmodule

// File: rtl/pll_fb_divider.sv
module pll_fb_divider
   import pfd_pkg::*;
#(
   parameter int                DATA_W   = 8,
   parameter int                ADDR_W   = 8,
   parameter int                MUL_W    = 12,
   parameter logic [ADDR_W-1:0] ADDR_HI  = 8'h37,
   parameter logic [ADDR_W-1:0] ADDR_LO  = 8'h38,
   parameter logic [ADDR_W-1:0] ADDR_RNG = 8'h3A,
   parameter logic [MUL_W-1:0]  MUL_RST  = 12'h040,
   parameter logic [DATA_W-1:0] RNG_RST  = 8'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pll_on,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              fb_pulse,
   output logic [MUL_W-1:0]  mul_value,
   output logic [DATA_W-1:0] range_value
);

   generate
      if (MUL_W <= DATA_W) begin : g_bad_mul_w
         $error("MUL_W must exceed DATA_W");
      end
      if (MUL_W > 2 * DATA_W) begin : g_bad_mul_w2
         $error("MUL_W must fit in two data bytes");
      end
      if (ADDR_HI == ADDR_LO || ADDR_HI == ADDR_RNG || ADDR_LO == ADDR_RNG) begin : g_bad_addr
         $error("register addresses must be distinct");
      end
   endgenerate

   reg_sel_e          sel;
   logic [MUL_W-1:0]  mul_q;
   logic [DATA_W-1:0] rng_q;

   pfd_cfg_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MUL_W(MUL_W),
      .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO), .ADDR_RNG(ADDR_RNG),
      .MUL_RST(MUL_RST), .RNG_RST(RNG_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .pll_on(pll_on), .wr_en(wr_en),
      .addr(addr), .wr_data(wr_data), .sel(sel), .mul_q(mul_q), .rng_q(rng_q)
   );

   pfd_read_mux #(
      .DATA_W(DATA_W), .MUL_W(MUL_W)
   ) u_rmux (
      .sel(sel), .mul_q(mul_q), .rng_q(rng_q), .rd_data(rd_data)
   );

   pfd_mod_counter #(
      .MUL_W(MUL_W)
   ) u_div (
      .clk(clk), .rst_n(rst_n), .pll_on(pll_on), .mul(mul_q), .pulse(fb_pulse)
   );

   assign mul_value   = mul_q;
   assign range_value = rng_q;

endmodule

// File: rtl/pll_fb_divider_chk.sv
module pll_fb_divider_chk #(
   parameter int                DATA_W  = 8,
   parameter int                ADDR_W  = 8,
   parameter int                MUL_W   = 12,
   parameter logic [ADDR_W-1:0] ADDR_HI = 8'h37
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pll_on,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              fb_pulse,
   input logic [MUL_W-1:0]  mul_value,
   input logic [DATA_W-1:0] range_value
);

   localparam int HI_W = MUL_W - DATA_W;

   logic             on_q;
   logic             seen;
   logic [MUL_W:0]   gap;
   logic [MUL_W:0]   n_chk;

   assign n_chk = (mul_value == '0) ? (MUL_W+1)'(1) : {1'b0, mul_value};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q <= 1'b0;
         seen <= 1'b0;
         gap  <= '0;
      end else begin
         on_q <= pll_on;
         if (!pll_on) begin
            seen <= 1'b0;
            gap  <= '0;
         end else if (fb_pulse) begin
            seen <= 1'b1;
            gap  <= (MUL_W+1)'(1);
         end else begin
            gap  <= gap + (MUL_W+1)'(1);
         end
      end
   end

   assert_mul_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pll_on |=> $stable(mul_value));

   assert_range_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pll_on |=> $stable(range_value));

   assert_hi_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_HI) |-> (rd_data[DATA_W-1:HI_W] == '0));

   assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_on |-> !fb_pulse);

   assert_zero_as_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_on && on_q && mul_value == '0) |-> fb_pulse);

   assert_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_on && seen && fb_pulse) |-> (gap == n_chk));

endmodule

bind pll_fb_divider pll_fb_divider_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MUL_W(MUL_W), .ADDR_HI(ADDR_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pll_on(pll_on), .addr(addr), .rd_data(rd_data),
   .fb_pulse(fb_pulse), .mul_value(mul_value), .range_value(range_value)
);

// File: tb/tb_pll_fb_divider.sv
module tb_pll_fb_divider;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pll_on = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [7:0]  wr_data = 8'h00;
   logic [7:0]  rd_data;
   logic        fb_pulse;
   logic [11:0] mul_value;
   logic [7:0]  range_value;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } item_t;

   item_t sb_q[$];
   item_t mon_it;
   logic  rd_req = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   pll_fb_divider dut (
      .clk(clk), .rst_n(rst_n), .pll_on(pll_on), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .fb_pulse(fb_pulse),
      .mul_value(mul_value), .range_value(range_value)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: compares read data away from the active edge
   always @(negedge clk) begin
      if (rd_req && sb_q.size() > 0) begin
         mon_it = sb_q.pop_front();
         check(rd_data === mon_it.exp, mon_it.tag, int'(rd_data), int'(mon_it.exp));
      end
   end

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, input logic [7:0] e, input string tag);
      item_t it;
      @(posedge clk); #1;
      addr = a;
      it.exp = e;
      it.tag = tag;
      sb_q.push_back(it);
      rd_req = 1'b1;
      @(posedge clk); #1;
      rd_req = 1'b0;
   endtask

   // Enable at a falling edge, then compare every cycle against N
   task automatic run_div(input int n, input string tag);
      bit ok = 1'b1;
      int bad_i = 0;
      logic act = 1'b0;
      @(negedge clk);
      pll_on = 1'b1;
      for (int i = 1; i <= 3 * n; i++) begin
         @(negedge clk);
         if (fb_pulse !== ((i % n) == 0) && ok) begin
            ok = 1'b0; bad_i = i; act = fb_pulse;
         end
      end
      check(ok, $sformatf("%s pulse at cycle %0d", tag, bad_i), int'(act), int'(!act));
      @(negedge clk);
      pll_on = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (i == 3) check(fb_pulse === 1'b0, "R8 no pulse while off", int'(fb_pulse), 0);
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      check(mul_value === 12'd64, "R1 mul_value after reset", int'(mul_value), 64);
      bus_read(8'h37, 8'h00, "R1 hi reset");
      bus_read(8'h38, 8'h40, "R1 lo reset");
      bus_read(8'h3A, 8'h40, "R1 range reset");
      check(fb_pulse === 1'b0, "R8 idle after reset", int'(fb_pulse), 0);

      // R6 default ratio
      run_div(64, "R6 N=64");

      // R2 / R3 writes while off
      bus_write(8'h38, 8'h05);
      bus_read(8'h38, 8'h05, "R2 lo readback");
      bus_write(8'h37, 8'hF3);
      bus_read(8'h37, 8'h03, "R3 hi upper bits zero");
      check(mul_value === 12'h305, "R2 mul_value hi+lo", int'(mul_value), 12'h305);
      bus_write(8'h37, 8'hF0);
      bus_read(8'h37, 8'h00, "R3 hi reads zero");
      check(mul_value === 12'h005, "R2 mul_value after hi clear", int'(mul_value), 5);

      // R4 / R5 lock while on
      @(negedge clk); pll_on = 1'b1;
      bus_write(8'h38, 8'h22);
      bus_write(8'h37, 8'h01);
      bus_write(8'h3A, 8'h99);
      bus_read(8'h38, 8'h05, "R4 lo locked");
      bus_read(8'h37, 8'h00, "R4 hi locked");
      bus_read(8'h3A, 8'h40, "R5 range locked");
      check(mul_value === 12'h005, "R4 mul_value locked", int'(mul_value), 5);
      @(negedge clk); pll_on = 1'b0;

      // R5 full-width range write
      bus_write(8'h3A, 8'hA5);
      bus_read(8'h3A, 8'hA5, "R5 range write");
      check(range_value === 8'hA5, "R5 range_value", int'(range_value), 8'hA5);

      // R9 unmapped reads
      bus_read(8'h39, 8'h00, "R9 addr 0x39");
      bus_read(8'h00, 8'h00, "R9 addr 0x00");
      bus_read(8'h3B, 8'h00, "R9 addr 0x3B");

      // R6 small ratio
      run_div(5, "R6 N=5");

      // R7 zero acts as one
      bus_write(8'h38, 8'h00);
      check(mul_value === 12'h000, "R7 mul_value zero", int'(mul_value), 0);
      run_div(1, "R7 N=0 as 1");

      // R10 write coincides with enable rising: discarded
      @(posedge clk); #1;
      pll_on = 1'b1; wr_en = 1'b1; addr = 8'h38; wr_data = 8'h07;
      @(posedge clk); #1;
      wr_en = 1'b0;
      bus_read(8'h38, 8'h00, "R10 write on rise dropped");
      // R10 write coincides with enable falling: accepted
      @(posedge clk); #1;
      pll_on = 1'b0; wr_en = 1'b1; addr = 8'h38; wr_data = 8'h03;
      @(posedge clk); #1;
      wr_en = 1'b0;
      bus_read(8'h38, 8'h03, "R10 write on fall taken");

      run_div(3, "R6 N=3");

      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule